// File: doc/BRIEF.md
# Pipelined Vector Rotator (Shift-Add Angle Rotation)

This block turns a complex sample `(x, y)` by an arbitrary angle using only adders, wired shifts and a fixed shift-add gain network. It is meant to stand in for the twiddle multiply of a pipelined FFT or a mixer stage: the caller presents a coordinate pair and an angle in radians, and a fixed number of cycles later the rotated pair comes out with the rotation gain already taken out.

Before the micro-rotations start, an angle larger than a right angle in either direction is reduced by a quarter-turn pre-rotation. That step swaps the coordinates and negates one of them, so that the remaining angle lies inside the range where the iterations converge. Fourteen micro-rotation stages follow. Each stage looks up a hard-wired arctangent constant, and the sign of the remaining angle decides whether the stage turns clockwise or anticlockwise. A register can follow every stage. A qualifying valid bit travels alongside the data, so a new sample can be accepted on every cycle.

Top module: `cordic_rotator`

## Requirements
- R1: Coordinates and angle use 15-bit two's complement with 10 fractional bits, so one LSB is 2^-10 and the angle is in radians. For a valid input, `out_x` is within 6 LSB of round(x·cos a − y·sin a) and `out_y` is within 6 LSB of round(x·sin a + y·cos a).
- R2: R1 holds for every angle with |a| ≤ π, including angles beyond ±π/2 that need the quarter-turn pre-rotation.
- R3: With stage registers enabled, `out_valid` rises exactly 15 cycles after the clock edge that samples `in_valid` high, and results leave in the order the inputs arrived.
- R4: A result whose magnitude exceeds the 15-bit range is clamped to +16383 or −16383. The code −16384 never appears on a valid output.
- R5: While `rst_n` is low, and after it is released, `out_valid` is 0 and both data outputs are 0. A cycle with `in_valid` low produces no valid output.
- R6: While `out_valid` is low, `out_x` and `out_y` hold the last valid result, whatever data is applied with `in_valid` low.
- R7: An angle of zero returns the input coordinates within 6 LSB, which shows that the gain correction cancels the growth of the micro-rotations.
- R8: Valid inputs on consecutive cycles each produce a correct result on consecutive cycles, with no bubbles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the input sample |
| in_x | input | 15 | Real part in, signed, 10 fractional bits |
| in_y | input | 15 | Imaginary part in, signed, 10 fractional bits |
| in_ang | input | 15 | Rotation angle in radians, signed, 10 fractional bits |
| out_valid | output | 1 | Qualifies the output sample |
| out_x | output | 15 | Rotated real part |
| out_y | output | 15 | Rotated imaginary part |

## Verification
Each result is due exactly 15 clock edges after the edge that samples its input. The bench keeps one expected entry per cycle in a queue, including the idle cycles. It drives inputs on the falling edge and, on each falling edge before driving, pops the entry pushed 15 cycles earlier. It compares `out_valid` every cycle. When the popped entry is valid, it compares both coordinates against ideal trigonometry computed from the quantized inputs. When the popped entry is idle, it checks that the outputs still hold the previous result. The quarter-turn folding, the clamped results and back-to-back streams all pass through this same cycle-exact comparison.

// File: rtl/cordic_pkg.sv
`timescale 1ns/1ps
package cordic_pkg;
  // internal angle resolution: 2^-16 rad
  localparam int ANG_FRAC  = 16;
  localparam int HALF_PI_Q = 102944;

  // arctan(2^-i) in units of 2^-ANG_FRAC rad
  function automatic int atan_q(input int i);
    case (i)
      0:  return 51472;
      1:  return 30386;
      2:  return 16055;
      3:  return 8150;
      4:  return 4091;
      5:  return 2047;
      6:  return 1024;
      7:  return 512;
      default: return (i <= ANG_FRAC) ? (1 << (ANG_FRAC - i + 1)) / 2 : 0;
    endcase
  endfunction
endpackage

// File: rtl/cordic_prerot.sv
`timescale 1ns/1ps
// Widens the inputs and folds angles beyond a right angle with a quarter turn.
module cordic_prerot #(
  parameter int DW = 15,
  parameter int DF = 10,
  parameter int GB = 2,
  parameter int IW = 19,
  parameter int AW = 22
) (
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [DW-1:0] a_i,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic signed [AW-1:0] a_o
);
  localparam int ASH = cordic_pkg::ANG_FRAC - DF;
  localparam logic signed [AW-1:0] HP = AW'(cordic_pkg::HALF_PI_Q);

  logic signed [IW-1:0] xe, ye;
  logic signed [AW-1:0] ae;

  always_comb begin
    xe = IW'(x_i) <<< GB;
    ye = IW'(y_i) <<< GB;
    ae = AW'(a_i) <<< ASH;
    if (ae > HP) begin
      x_o = -ye;
      y_o = xe;
      a_o = ae - HP;
    end else if (ae < -HP) begin
      x_o = ye;
      y_o = -xe;
      a_o = ae + HP;
    end else begin
      x_o = xe;
      y_o = ye;
      a_o = ae;
    end
  end
endmodule

// File: rtl/cordic_stage.sv
`timescale 1ns/1ps
// One micro-rotation: direction from the residual sign, shift by IDX.
module cordic_stage #(
  parameter int IW   = 19,
  parameter int AW   = 22,
  parameter int IDX  = 0,
  parameter bit PIPE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_i,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic signed [AW-1:0] a_i,
  output logic                 v_o,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic signed [AW-1:0] a_o
);
  localparam logic signed [AW-1:0] STEP = AW'(cordic_pkg::atan_q(IDX));

  logic signed [IW-1:0] xs, ys, x_n, y_n;
  logic signed [AW-1:0] a_n;

  always_comb begin
    xs = x_i >>> IDX;
    ys = y_i >>> IDX;
    if (!a_i[AW-1]) begin
      x_n = x_i - ys;
      y_n = y_i + xs;
      a_n = a_i - STEP;
    end else begin
      x_n = x_i + ys;
      y_n = y_i - xs;
      a_n = a_i + STEP;
    end
  end

  if (PIPE) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_o <= 1'b0;
        x_o <= '0;
        y_o <= '0;
        a_o <= '0;
      end else begin
        v_o <= v_i;
        if (v_i) begin
          x_o <= x_n;
          y_o <= y_n;
          a_o <= a_n;
        end
      end
    end
  end else begin : g_wire
    assign v_o = v_i;
    assign x_o = x_n;
    assign y_o = y_n;
    assign a_o = a_n;
  end
endmodule

// File: rtl/cordic_gain.sv
`timescale 1ns/1ps
// Constant gain correction (~0.60730) by shifts and adds, drop guard bits, clamp.
module cordic_gain #(
  parameter int DW = 15,
  parameter int GB = 2,
  parameter int IW = 19
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_i,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  output logic                 v_o,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o
);
  localparam int KS = 13;
  localparam int WW = IW + KS;
  localparam logic signed [WW-1:0] MAXV = WW'((1 << (DW - 1)) - 1);

  function automatic logic signed [WW-1:0] scale(input logic signed [WW-1:0] v);
    return (v >>> 1) + (v >>> 3) - (v >>> 6) - (v >>> 9) - (v >>> 12) + (v >>> 13);
  endfunction

  function automatic logic signed [DW-1:0] clamp(input logic signed [WW-1:0] v);
    if (v > MAXV)       return DW'(MAXV);
    else if (v < -MAXV) return DW'(-MAXV);
    else                return DW'(v);
  endfunction

  logic signed [WW-1:0] xw, yw;
  logic signed [DW-1:0] x_n, y_n;

  always_comb begin
    xw  = scale($signed({x_i, {KS{1'b0}}})) >>> (KS + GB);
    yw  = scale($signed({y_i, {KS{1'b0}}})) >>> (KS + GB);
    x_n = clamp(xw);
    y_n = clamp(yw);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0;
      x_o <= '0;
      y_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        x_o <= x_n;
        y_o <= y_n;
      end
    end
  end
endmodule

// File: rtl/cordic_rotator.sv
`timescale 1ns/1ps
module cordic_rotator #(
  parameter int DW   = 15,
  parameter int DF   = 10,
  parameter int GB   = 2,
  parameter int NST  = 14,
  parameter bit PIPE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_x,
  input  logic signed [DW-1:0] in_y,
  input  logic signed [DW-1:0] in_ang,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_x,
  output logic signed [DW-1:0] out_y
);
  localparam int IW = DW + 2 + GB;
  localparam int AW = DW + (cordic_pkg::ANG_FRAC - DF) + 1;

  logic                 sv [NST+1];
  logic signed [IW-1:0] sx [NST+1];
  logic signed [IW-1:0] sy [NST+1];
  logic signed [AW-1:0] sa [NST+1];
  logic signed [AW-1:0] fold_ang;

  cordic_prerot #(.DW(DW), .DF(DF), .GB(GB), .IW(IW), .AW(AW)) u_pre (
    .x_i(in_x), .y_i(in_y), .a_i(in_ang),
    .x_o(sx[0]), .y_o(sy[0]), .a_o(fold_ang)
  );
  assign sa[0] = fold_ang;
  assign sv[0] = in_valid;

  for (genvar i = 0; i < NST; i++) begin : g_st
    cordic_stage #(.IW(IW), .AW(AW), .IDX(i), .PIPE(PIPE)) u_st (
      .clk(clk), .rst_n(rst_n),
      .v_i(sv[i]), .x_i(sx[i]), .y_i(sy[i]), .a_i(sa[i]),
      .v_o(sv[i+1]), .x_o(sx[i+1]), .y_o(sy[i+1]), .a_o(sa[i+1])
    );
  end

  logic signed [AW-1:0] ang_left;
  assign ang_left = sa[NST];

  cordic_gain #(.DW(DW), .GB(GB), .IW(IW)) u_gain (
    .clk(clk), .rst_n(rst_n),
    .v_i(sv[NST]), .x_i(sx[NST]), .y_i(sy[NST]),
    .v_o(out_valid), .x_o(out_x), .y_o(out_y)
  );
endmodule

// File: rtl/cordic_rotator_chk.sv
`timescale 1ns/1ps
module cordic_rotator_chk #(
  parameter int DW  = 15,
  parameter int DF  = 10,
  parameter int AW  = 22,
  parameter int LAT = 15
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_ang,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_x,
  input logic signed [DW-1:0] out_y,
  input logic signed [AW-1:0] fold_ang
);
  localparam int PI_LIM = (2 * cordic_pkg::HALF_PI_Q) >> (cordic_pkg::ANG_FRAC - DF);
  localparam logic signed [AW-1:0] HP = AW'(cordic_pkg::HALF_PI_Q);
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic [LAT-1:0] vhist;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vhist <= '0;
    else        vhist <= (vhist << 1) | LAT'(in_valid);
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vhist[LAT-1]); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_x) && $stable(out_y))); // R6

  AST_SAT_SYMMETRIC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_x != MINV && out_y != MINV)); // R4

  AST_FOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ang <= PI_LIM && in_ang >= -PI_LIM) |-> (fold_ang <= HP && fold_ang >= -HP)); // R2
endmodule

bind cordic_rotator cordic_rotator_chk #(
  .DW(DW), .DF(DF), .AW(AW), .LAT(PIPE ? NST + 1 : 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ang(in_ang),
  .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .fold_ang(fold_ang)
);

// File: tb/sim_cordic_rotator.sv
`timescale 1ns/1ps
module sim_cordic_rotator;
  localparam int LAT  = 15;
  localparam int TOL  = 6;
  localparam int MAXV = 16383;

  logic clk, rst_n, in_valid;
  logic signed [14:0] in_x, in_y, in_ang;
  logic out_valid;
  logic signed [14:0] out_x, out_y;

  int total = 0, bad = 0;
  int last_x = 0, last_y = 0;
  bit done = 0;

  bit    qv[$];
  real   qx[$], qy[$];
  string qt[$];

  cordic_rotator u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_x(in_x), .in_y(in_y), .in_ang(in_ang),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int clampi(input real v);
    int r;
    r = int'(v);
    if (r > MAXV) r = MAXV;
    if (r < -MAXV) r = -MAXV;
    return r;
  endfunction

  task automatic check_coord(input string tag, input string nm, input int act, input real ideal);
    int e, d;
    bit hard;
    e = clampi(ideal);
    d = act - e;
    if (d < 0) d = -d;
    hard = (ideal > MAXV + TOL) || (ideal < -MAXV - TOL);
    total++;
    if (hard ? (act != e) : (d > TOL)) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, nm, act, e);
    end
  endtask

  task automatic compare_out();
    bit ev; real ex, ey; string t;
    ev = qv.pop_front(); ex = qx.pop_front(); ey = qy.pop_front(); t = qt.pop_front();
    total++;
    if (out_valid !== ev) begin
      bad++;
      $display("FAIL R3 out_valid (%s): actual=%0d expected=%0d", t, out_valid, ev);
    end
    if (ev) begin
      check_coord(t, "x", int'(out_x), ex);
      check_coord(t, "y", int'(out_y), ey);
      last_x = int'(out_x);
      last_y = int'(out_y);
    end else begin
      total++;
      if (int'(out_x) != last_x || int'(out_y) != last_y) begin
        bad++;
        $display("FAIL R6 hold: actual=%0d,%0d expected=%0d,%0d",
                 out_x, out_y, last_x, last_y);
      end
    end
  endtask

  // one clock: check the result due now, then drive and record the next input
  task automatic cyc(input bit v, input real x, input real y, input real a, input string tag);
    int xi, yi, ai;
    real xq, yq, aq;
    @(negedge clk);
    if (qv.size() == LAT) compare_out();
    xi = int'(x * 1024.0); yi = int'(y * 1024.0); ai = int'(a * 1024.0);
    xq = xi; yq = yi; aq = ai / 1024.0;
    in_valid = v;
    in_x = 15'(xi); in_y = 15'(yi); in_ang = 15'(ai);
    qv.push_back(v);
    qx.push_back(xq * $cos(aq) - yq * $sin(aq));
    qy.push_back(xq * $sin(aq) + yq * $cos(aq));
    qt.push_back(tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_x = '0; in_y = '0; in_ang = '0;
    repeat (4) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || out_x !== 15'sd0 || out_y !== 15'sd0) begin
      bad++;
      $display("FAIL R5 reset: actual=%0d/%0d/%0d expected=0/0/0", out_valid, out_x, out_y);
    end
    @(negedge clk); rst_n = 1'b1;
    // pipeline starts empty: the first LAT outputs must be idle (R5)
    for (int k = 0; k < LAT; k++) begin
      qv.push_back(1'b0); qx.push_back(0.0); qy.push_back(0.0); qt.push_back("R5");
    end
    // R7 zero angle gives the input back
    cyc(1, 3.5, -2.25, 0.0, "R7");
    cyc(1, -7.0, 6.0, 0.0, "R7");
    // R1 in-range angles
    cyc(1, 1.0, 0.0, 0.5236, "R1");
    cyc(1, 4.0, 2.0, -1.2, "R1");
    cyc(1, -3.0, 5.5, 1.0, "R1");
    cyc(0, 9.0, 9.0, 2.0, "R5");
    // R2 angles that need the quarter-turn fold
    cyc(1, 2.0, 1.0, 2.5, "R2");
    cyc(1, -5.0, 3.0, -2.9, "R2");
    cyc(1, 6.0, -4.0, 3.1, "R2");
    cyc(1, 1.5, 7.0, -1.6, "R2");
    // R6 idle cycles with junk data on the inputs
    for (int k = 0; k < 20; k++) cyc(0, -11.0 + k, 5.0, 1.0, "R6");
    // R8 back-to-back stream
    for (int k = 0; k < 24; k++)
      cyc(1, ((k * 37) % 33 - 16) * 0.25, ((k * 53) % 29 - 14) * 0.3,
          ((k * 71) % 61 - 30) * 0.1, "R8");
    // R4 clamp
    cyc(1, 15.5, 15.5, 0.7854, "R4");
    cyc(1, 15.5, 15.5, -2.3562, "R4");
    cyc(1, -15.0, 14.0, 2.4, "R4");
    for (int k = 0; k < LAT + 2; k++) cyc(0, 0.0, 0.0, 0.0, "R5");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule